// File: doc/BRIEF.md
# SDRAM Power-Down and Self-Refresh Manager

This block runs in the memory clock domain and decides which low-power condition the attached SDRAM is in. It can be fully powered, in power-down or in self-refresh. While the memory is powered, the block counts consecutive idle cycles. When a programmed count is reached and automatic power-down is enabled, it issues a power-down entry command. A later access command brings the device straight back out.

Self-refresh is never entered on the block's own initiative. The control domain raises a level request, typically after a software sleep command or a hardware low-power request. The block answers with a self-refresh entry command. After a fixed settle time it may stop the external memory clock, if configuration allows this. It then holds the device in self-refresh until a wake request arrives. On wake it restarts the clock a fixed number of cycles ahead of the exit command. After a programmable exit delay it returns a one-cycle wake acknowledge.

All command outputs are single-cycle pulses to a downstream command sequencer. There is no data path, so every pin is plain control or status.

Top module: `sdram_pwr_mgr`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pwr_state` is 0 (powered), `mem_clk_en` is 1, `sr_ack` is 0 and every command and acknowledge output is 0.
- R2: In state 0 with `cfg_auto_pd`=1 and `cfg_idle_prd`=N>0, the clock edge that samples the N-th consecutive cycle with `acc_req`, `ref_pend` and `sr_req` all low moves the block to `pwr_state` 1. `cmd_pde` is high for exactly the first cycle of that state.
- R3: A cycle with `acc_req` or `ref_pend` high restarts the idle count from zero.
- R4: With `cfg_auto_pd`=0 or `cfg_idle_prd`=0, the block never enters power-down, however long it is idle.
- R5: In power-down, an `acc_req` sampled at an edge returns the block to state 0 in the next cycle, with a single `cmd_pdx` pulse.
- R6: In state 0, `sr_req` sampled at an edge gives `cmd_sre` and `pwr_state` 2 in the next cycle. It takes priority over an idle expiry in the same cycle.
- R7: An `sr_req` sampled in power-down first gives one cycle of `cmd_pdx` with state 0. `cmd_sre` follows in the very next cycle.
- R8: With `cfg_clk_stop_en`=1, `mem_clk_en` falls SETTLE_CYC cycles after the `cmd_sre` cycle, and this is also the cycle where `sr_ack` rises. With `cfg_clk_stop_en`=0, the clock stays enabled throughout self-refresh. `mem_clk_en` is never low outside the settled self-refresh state.
- R9: Once `sr_ack` is high, `acc_req`, `ref_pend` and `sr_req` have no effect. State 2 and `sr_ack` hold with no command until `wake_req` is sampled.
- R10: On `wake_req` with the clock stopped, `mem_clk_en` rises in the next cycle and `cmd_srx` follows LEAD_CYC cycles later. With the clock running, `cmd_srx` comes in the next cycle.
- R11: After the `cmd_srx` cycle, `pwr_state` is 3 (waking). `wake_ack` pulses for one cycle exactly `cfg_exit_dly`+1 cycles after the `cmd_srx` cycle, together with the return to state 0.
- R12: `sr_ack` is high only in the settled self-refresh state, from the end of the settle time until wake is taken.
- R13: At most one of `cmd_pde`, `cmd_pdx`, `cmd_sre`, `cmd_srx`, `wake_ack` is high in any cycle, and each is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_auto_pd | input | 1 | Enable automatic power-down |
| cfg_idle_prd | input | IDLE_W | Idle cycles before power-down, 0 disables |
| cfg_clk_stop_en | input | 1 | Allow stopping the external clock in self-refresh |
| cfg_exit_dly | input | EXIT_W | Extra cycles after exit before wake acknowledge |
| acc_req | input | 1 | An SDRAM access command is arriving |
| ref_pend | input | 1 | A refresh is pending |
| sr_req | input | 1 | Level request to enter self-refresh |
| wake_req | input | 1 | Level request to leave self-refresh |
| pwr_state | output | 2 | 0 powered, 1 power-down, 2 self-refresh, 3 waking |
| mem_clk_en | output | 1 | Enable for the external memory clock |
| sr_ack | output | 1 | Device settled in self-refresh |
| wake_ack | output | 1 | One-cycle pulse, wake sequence complete |
| cmd_pde | output | 1 | Power-down entry command pulse |
| cmd_pdx | output | 1 | Power-down exit command pulse |
| cmd_sre | output | 1 | Self-refresh entry command pulse |
| cmd_srx | output | 1 | Self-refresh exit command pulse |

## Verification
The bench builds the block with a 6-bit idle period, a 4-bit exit delay, SETTLE_CYC=4 and LEAD_CYC=3. These small values let the idle timeout expire many times in a short run. Random period values from 0 to 11 and exit delays from 0 to 5 cover the disabled-timer case, the one-cycle timeout and the zero exit delay. The short settle and lead windows make clock-stop and restart sequences frequent enough for random traffic to strike them mid-sequence.

// File: rtl/sdram_pm_pkg.sv
package sdram_pm_pkg;
  typedef enum logic [2:0] {
    PM_UP,
    PM_PD,
    PM_SETTLE,
    PM_SR,
    PM_LEAD,
    PM_EXIT
  } pm_state_e;

  localparam logic [1:0] PWR_UP   = 2'd0;
  localparam logic [1:0] PWR_PD   = 2'd1;
  localparam logic [1:0] PWR_SR   = 2'd2;
  localparam logic [1:0] PWR_WAKE = 2'd3;
endpackage

// File: rtl/sdram_pm_idle_timer.sv
module sdram_pm_idle_timer #(
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              activity,
  input  logic              enable,
  input  logic [IDLE_W-1:0] period,
  output logic              expire
);
  logic [IDLE_W-1:0] cnt_q;
  logic              armed;

  assign armed  = enable && (period != '0);
  assign expire = run && armed && !activity && (cnt_q >= period - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || activity || !armed || expire) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sdram_pm_delay.sv
module sdram_pm_delay #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DLY_W-1:0] target,
  output logic             done
);
  logic [DLY_W-1:0] cnt_q;

  assign done = (cnt_q >= target);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q <= '0;
    end else if (!done) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sdram_pwr_mgr.sv
module sdram_pwr_mgr
  import sdram_pm_pkg::*;
#(
  parameter int IDLE_W     = 8,
  parameter int EXIT_W     = 8,
  parameter int SETTLE_CYC = 4,
  parameter int LEAD_CYC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_auto_pd,
  input  logic [IDLE_W-1:0] cfg_idle_prd,
  input  logic              cfg_clk_stop_en,
  input  logic [EXIT_W-1:0] cfg_exit_dly,
  input  logic              acc_req,
  input  logic              ref_pend,
  input  logic              sr_req,
  input  logic              wake_req,
  output logic [1:0]        pwr_state,
  output logic              mem_clk_en,
  output logic              sr_ack,
  output logic              wake_ack,
  output logic              cmd_pde,
  output logic              cmd_pdx,
  output logic              cmd_sre,
  output logic              cmd_srx
);
  localparam int SL_MAX = (SETTLE_CYC > LEAD_CYC) ? SETTLE_CYC : LEAD_CYC;
  localparam int SL_W   = $clog2(SL_MAX + 1);
  localparam int DLY_W  = (EXIT_W > SL_W) ? EXIT_W : SL_W;
  localparam logic [DLY_W-1:0] SETTLE_TGT = DLY_W'(SETTLE_CYC - 1);
  localparam logic [DLY_W-1:0] LEAD_TGT   = DLY_W'(LEAD_CYC - 1);

  pm_state_e        st_q, st_d;
  logic             clk_en_q, clk_en_d;
  logic             pde_q, pdx_q, sre_q, srx_q, wack_q;
  logic             pde_d, pdx_d, sre_d, srx_d, wack_d;
  logic             idle_exp;
  logic             dly_done;
  logic             dly_clr;
  logic [DLY_W-1:0] dly_tgt;

  sdram_pm_idle_timer #(.IDLE_W(IDLE_W)) u_idle (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (st_q == PM_UP),
    .activity (acc_req || ref_pend),
    .enable   (cfg_auto_pd),
    .period   (cfg_idle_prd),
    .expire   (idle_exp)
  );

  always_comb begin
    case (st_q)
      PM_SETTLE: dly_tgt = SETTLE_TGT;
      PM_LEAD:   dly_tgt = LEAD_TGT;
      default:   dly_tgt = DLY_W'(cfg_exit_dly);
    endcase
  end

  assign dly_clr = (st_d != st_q);

  sdram_pm_delay #(.DLY_W(DLY_W)) u_dly (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (dly_clr),
    .target (dly_tgt),
    .done   (dly_done)
  );

  // Next-state and command decode; commands are registered with the state.
  always_comb begin
    st_d     = st_q;
    clk_en_d = clk_en_q;
    pde_d    = 1'b0;
    pdx_d    = 1'b0;
    sre_d    = 1'b0;
    srx_d    = 1'b0;
    wack_d   = 1'b0;
    case (st_q)
      PM_UP: begin
        if (sr_req) begin
          st_d  = PM_SETTLE;
          sre_d = 1'b1;
        end else if (idle_exp) begin
          st_d  = PM_PD;
          pde_d = 1'b1;
        end
      end
      PM_PD: begin
        if (acc_req || sr_req) begin
          st_d  = PM_UP;
          pdx_d = 1'b1;
        end
      end
      PM_SETTLE: begin
        if (dly_done) begin
          st_d = PM_SR;
          if (cfg_clk_stop_en) clk_en_d = 1'b0;
        end
      end
      PM_SR: begin
        if (wake_req) begin
          if (clk_en_q) begin
            st_d  = PM_EXIT;
            srx_d = 1'b1;
          end else begin
            st_d     = PM_LEAD;
            clk_en_d = 1'b1;
          end
        end
      end
      PM_LEAD: begin
        if (dly_done) begin
          st_d  = PM_EXIT;
          srx_d = 1'b1;
        end
      end
      PM_EXIT: begin
        if (dly_done) begin
          st_d   = PM_UP;
          wack_d = 1'b1;
        end
      end
      default: st_d = PM_UP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= PM_UP;
      clk_en_q <= 1'b1;
      pde_q    <= 1'b0;
      pdx_q    <= 1'b0;
      sre_q    <= 1'b0;
      srx_q    <= 1'b0;
      wack_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      clk_en_q <= clk_en_d;
      pde_q    <= pde_d;
      pdx_q    <= pdx_d;
      sre_q    <= sre_d;
      srx_q    <= srx_d;
      wack_q   <= wack_d;
    end
  end

  always_comb begin
    case (st_q)
      PM_UP:   pwr_state = PWR_UP;
      PM_PD:   pwr_state = PWR_PD;
      PM_EXIT: pwr_state = PWR_WAKE;
      default: pwr_state = PWR_SR;
    endcase
  end

  assign mem_clk_en = clk_en_q;
  assign sr_ack     = (st_q == PM_SR);
  assign wake_ack   = wack_q;
  assign cmd_pde    = pde_q;
  assign cmd_pdx    = pdx_q;
  assign cmd_sre    = sre_q;
  assign cmd_srx    = srx_q;

  AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_pde, cmd_pdx, cmd_sre, cmd_srx, wake_ack})); // R13
  AST_PDE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pde |-> $past(cfg_auto_pd) && ($past(cfg_idle_prd) != '0)); // R4
  AST_PDX_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PM_PD && acc_req) |=> (cmd_pdx && pwr_state == PWR_UP)); // R5
  AST_SRE_FROM_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PM_UP && sr_req) |=> (cmd_sre && pwr_state == PWR_SR)); // R6
  AST_CLK_ONLY_SR: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_clk_en |-> sr_ack); // R8
  AST_SR_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_ack && !wake_req) |=> (sr_ack && !cmd_srx)); // R9
  AST_WACK_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_ack |-> (pwr_state == PWR_UP && $past(pwr_state) == PWR_WAKE)); // R11
endmodule

// File: tb/tb_sdram_pwr_mgr.sv
module tb_sdram_pwr_mgr;
  localparam int IW = 6;
  localparam int XW = 4;
  localparam int SC = 4;
  localparam int LC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          cfg_auto_pd = 1'b1;
  logic [IW-1:0] cfg_idle_prd = 6'd5;
  logic          cfg_clk_stop_en = 1'b1;
  logic [XW-1:0] cfg_exit_dly = 4'd2;
  logic          acc_req = 1'b0, ref_pend = 1'b0, sr_req = 1'b0, wake_req = 1'b0;
  logic [1:0]    pwr_state;
  logic          mem_clk_en, sr_ack, wake_ack, cmd_pde, cmd_pdx, cmd_sre, cmd_srx;

  sdram_pwr_mgr #(.IDLE_W(IW), .EXIT_W(XW), .SETTLE_CYC(SC), .LEAD_CYC(LC)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_auto_pd(cfg_auto_pd), .cfg_idle_prd(cfg_idle_prd),
    .cfg_clk_stop_en(cfg_clk_stop_en), .cfg_exit_dly(cfg_exit_dly),
    .acc_req(acc_req), .ref_pend(ref_pend), .sr_req(sr_req), .wake_req(wake_req),
    .pwr_state(pwr_state), .mem_clk_en(mem_clk_en), .sr_ack(sr_ack), .wake_ack(wake_ack),
    .cmd_pde(cmd_pde), .cmd_pdx(cmd_pdx), .cmd_sre(cmd_sre), .cmd_srx(cmd_srx));

  int n_cmp = 0;
  int n_bad = 0;

  // Reference model: 0 up, 1 pd, 2 settle, 3 sr, 4 lead, 5 exit
  int m_st = 0, m_idle = 0, m_c = 0;
  bit m_clk = 1'b1, p_pde, p_pdx, p_sre, p_srx, p_wack;

  function automatic logic [9:0] model_out();
    logic [1:0] ps;
    case (m_st)
      0: ps = 2'd0;
      1: ps = 2'd1;
      5: ps = 2'd3;
      default: ps = 2'd2;
    endcase
    return {ps, m_clk, (m_st == 3), p_pde, p_pdx, p_sre, p_srx, p_wack};
  endfunction

  function automatic logic [9:0] dut_out();
    return {pwr_state, mem_clk_en, sr_ack, cmd_pde, cmd_pdx, cmd_sre, cmd_srx, wake_ack};
  endfunction

  task automatic model_step();
    p_pde = 0; p_pdx = 0; p_sre = 0; p_srx = 0; p_wack = 0;
    case (m_st)
      0: begin
        if (sr_req) begin m_st = 2; p_sre = 1; m_c = 0; m_idle = 0; end
        else if (acc_req || ref_pend || !cfg_auto_pd || cfg_idle_prd == 0) m_idle = 0;
        else if (m_idle + 1 >= int'(cfg_idle_prd)) begin m_st = 1; p_pde = 1; m_idle = 0; end
        else m_idle++;
      end
      1: if (acc_req || sr_req) begin m_st = 0; p_pdx = 1; m_idle = 0; end
      2: begin
        if (m_c >= SC - 1) begin m_st = 3; m_c = 0; if (cfg_clk_stop_en) m_clk = 0; end
        else m_c++;
      end
      3: if (wake_req) begin
        m_c = 0;
        if (m_clk) begin m_st = 5; p_srx = 1; end
        else begin m_st = 4; m_clk = 1; end
      end
      4: begin
        if (m_c >= LC - 1) begin m_st = 5; p_srx = 1; m_c = 0; end
        else m_c++;
      end
      5: begin
        if (m_c >= int'(cfg_exit_dly)) begin m_st = 0; p_wack = 1; m_idle = 0; end
        else m_c++;
      end
      default: m_st = 0;
    endcase
  endtask

  task automatic compare(input string tag);
    n_cmp++;
    if (dut_out() !== model_out()) begin
      n_bad++;
      $display("FAIL %s: outputs actual=%b expected=%b", tag, dut_out(), model_out());
    end
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input string tag);
    model_step();
    @(posedge clk);
    #2;
    compare(tag);
  endtask

  // Ticks until the selected output is high, returns the tick count
  task automatic wait_for(input int which, input string tag, output int n);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      tick(tag);
      n++;
      if ((which == 0 && cmd_pde) || (which == 1 && !mem_clk_en) ||
          (which == 2 && cmd_srx) || (which == 3 && wake_ack) ||
          (which == 4 && sr_ack)) break;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int n;
    int unused;
    // R1: reset state
    repeat (3) @(posedge clk);
    #2;
    compare("R1 in reset");
    rst_n = 1'b1;
    tick("R1 first cycle");
    chk(pwr_state == 0 && mem_clk_en && !cmd_pde, "R1", pwr_state, 0);

    // R2: idle timeout of 5 (one idle tick already taken)
    wait_for(0, "R2", n);
    chk(n == 4 && pwr_state == 1, "R2 pde after 5 idle cycles", n + 1, 5);
    tick("R2 stays pd");
    chk(pwr_state == 1 && !cmd_pde, "R2 single pulse", pwr_state, 1);

    // R5: access exits power-down
    acc_req = 1; tick("R5");
    chk(cmd_pdx && pwr_state == 0, "R5 pdx", pwr_state, 0);
    acc_req = 0;

    // R3: activity restarts the idle count
    repeat (3) tick("R3");
    ref_pend = 1; tick("R3"); ref_pend = 0;
    repeat (4) tick("R3");
    chk(pwr_state == 0, "R3 count restarted", pwr_state, 0);
    tick("R3");
    chk(pwr_state == 1 && cmd_pde, "R3 expiry", pwr_state, 1);
    acc_req = 1; tick("R5"); acc_req = 0;

    // R4: disabled timer
    cfg_auto_pd = 0;
    repeat (30) tick("R4");
    chk(pwr_state == 0, "R4 auto off", pwr_state, 0);
    cfg_auto_pd = 1; cfg_idle_prd = 0;
    repeat (30) tick("R4");
    chk(pwr_state == 0, "R4 period zero", pwr_state, 0);
    cfg_idle_prd = 6'd5;

    // R6 and R8: self-refresh with clock stop
    repeat (2) tick("R6");
    sr_req = 1; tick("R6");
    chk(cmd_sre && pwr_state == 2, "R6 sre", pwr_state, 2);
    wait_for(1, "R8", n);
    chk(n == SC && sr_ack, "R8 settle before clock stop", n, SC);
    sr_req = 0;

    // R9: inputs ignored in self-refresh
    acc_req = 1; ref_pend = 1; sr_req = 1;
    repeat (10) tick("R9");
    chk(pwr_state == 2 && sr_ack && !mem_clk_en, "R9 held", pwr_state, 2);
    acc_req = 0; ref_pend = 0; sr_req = 0;

    // R10 and R11: wake with clock restart lead
    wake_req = 1; tick("R10");
    chk(mem_clk_en && !cmd_srx && !sr_ack, "R10 clock on first", mem_clk_en, 1);
    wait_for(2, "R10", n);
    chk(n == LC, "R10 lead cycles", n, LC);
    tick("R11");
    chk(pwr_state == 3, "R11 waking", pwr_state, 3);
    wait_for(3, "R11", n);
    chk(n + 1 == 3, "R11 exit delay", n + 1, 3);
    chk(pwr_state == 0, "R11 back up", pwr_state, 0);
    wake_req = 0;

    // R7 and R12: request while powered down, clock stop disabled
    cfg_clk_stop_en = 0; cfg_exit_dly = 0;
    wait_for(0, "R7", n);
    sr_req = 1; tick("R7");
    chk(cmd_pdx && pwr_state == 0, "R7 pdx first", pwr_state, 0);
    tick("R7");
    chk(cmd_sre && pwr_state == 2, "R7 sre second", pwr_state, 2);
    tick("R12");
    chk(!sr_ack, "R12 not yet settled", sr_ack, 0);
    wait_for(4, "R12", n);
    chk(n == SC - 1 && mem_clk_en, "R8 clock kept running", n, SC - 1);
    sr_req = 0;
    repeat (5) tick("R8");
    chk(mem_clk_en && sr_ack, "R8 clock on in sr", mem_clk_en, 1);
    wake_req = 1; tick("R10");
    chk(cmd_srx, "R10 srx without lead", cmd_srx, 1);
    tick("R11");
    chk(wake_ack && pwr_state == 0, "R11 zero delay", wake_ack, 1);
    wake_req = 0;

    // R13: constrained random traffic against the model
    unused = $urandom(2024);
    for (int i = 0; i < 4000; i++) begin
      if (i % 500 == 0) begin
        cfg_auto_pd = ($urandom % 4) != 0;
        cfg_idle_prd = IW'($urandom % 12);
        cfg_clk_stop_en = $urandom % 2;
        cfg_exit_dly = XW'($urandom % 6);
      end
      acc_req = ($urandom % 8) == 0;
      ref_pend = ($urandom % 16) == 0;
      if (sr_ack) sr_req = 0;
      else if (!sr_req && (m_st == 0 || m_st == 1) && ($urandom % 60) == 0) sr_req = 1;
      if (wake_ack) wake_req = 0;
      else if (m_st == 3 && ($urandom % 6) == 0) wake_req = 1;
      tick("R13 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule